// File: doc/BRIEF.md
# Resonant converter gate timing generator

This block drives the eight gate signals of a bidirectional resonant DC-DC converter built from two four-switch full bridges, one on each side of the transformer. Switching frequency is set by a half-period length in clock cycles, so an outer frequency control loop can move the converter across its operating range by rewriting one word. At 125 MHz, a half-period count of about 390 gives 160 kHz and about 1560 gives 40 kHz. A dead-time count holds both pairs of a bridge off at the start of every half-period.

In forward power flow, the first-side diagonal pairs alternate. The second-side diagonal pairs act as synchronous rectifiers: each rectifier pulse rises together with its matching first-side pair and lasts a programmed on-time. That on-time is clamped to the active part of the half-period, so at frequencies above resonance it fills the whole half-period. In backward flow, the second-side pairs alternate and every first-side gate stays off. For light loads in forward flow, a half-bridge option holds one first-side leg static.

Timing words are taken up only at half-period boundaries. Direction and bridge configuration are taken up only at the start of a full period. A one-cycle strobe marks the first cycle of each half-period as seen at the gate outputs.

Top module: `rgate_timer`

## Requirements
- R1: Gate bit i drives switch i+1 (bit 0 is switch 1, bit 7 is switch 8). Switches 5 and 8 always carry the same level, and so do switches 6 and 7. In forward full-bridge operation, switch 1 equals switch 4 and switch 2 equals switch 3.
- R2: A half-period lasts H cycles, where H is the half-period count taken at that half-period's start. Half-periods alternate between phase A and phase B, and the first one after enabling is phase A. Let k be the cycle index within a half-period, with k = 0 being the cycle in which the strobe is high. The phase-A switching pair is on for k >= D and the phase-B pair for k >= D. The two pairs are never on together.
- R3: For the first D cycles of every half-period (k < D), where D is the dead-time count, every switching first-side and second-side pair is off.
- R4: In forward operation, switches 5 and 8 are on in phase A for D <= k < D+S, and switches 6 and 7 are on for the same cycles in phase B, where S is the on-time count.
- R5: The on-time is clamped to H−D. An on-time count of H−D or more gives a rectifier pulse that lasts until the end of the half-period, and the two rectifier pairs are never on together.
- R6: With the direction input at 1 (backward), switches 1 to 4 are off. Switches 5 and 8 are on in phase A and switches 6 and 7 in phase B, each for k >= D. The on-time count has no effect.
- R7: With the configuration input at 1 in forward operation, switch 3 is held off and switch 4 is held on while running. Switch 1 is on for k >= D in phase A and switch 2 for k >= D in phase B. In backward operation the configuration input has no effect.
- R8: Changes to the half-period, dead-time or on-time counts in the middle of a half-period do not alter that half-period. They apply from the next one.
- R9: Changes to direction or configuration apply only from the next phase A. The phase B already under way keeps the previous mode.
- R10: During reset, and from the cycle after enable is sampled low, all gates and the strobe are 0. After enable is sampled high, the first strobe appears two falling edges after enable was raised.
- R11: A half-period count below D+2 is treated as D+2.
- R12: The strobe is high for exactly one cycle per half-period, at k = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low forces all gates off |
| half_len | input | CNT_W | Half-period length in cycles |
| dead_len | input | DT_W | Dead time in cycles |
| sr_len | input | CNT_W | Synchronous-rectifier on-time in cycles |
| dir_bwd | input | 1 | 0 forward, 1 backward |
| half_br | input | 1 | 1 selects half-bridge in forward operation |
| gate | output | 8 | Gate drives, bit i for switch i+1 |
| hp_start | output | 1 | One-cycle strobe at the start of each half-period |

## Verification
The assertions watch, on every cycle, the properties that hold regardless of timing:
- the diagonal pairing of the rectifier switches;
- mutual exclusion of opposing pairs;
- the silent first side in backward flow;
- the static leg in half-bridge mode;
- forced-off gates while disabled;
- single-cycle strobes.

Only the directed scenarios can show the exact rising and falling cycles of each pulse against dead time, on-time and clamping. The same holds for whether a mid-period change of timing words or mode waits for the correct boundary.

// File: rtl/rgate_timer.sv
module rgate_timer #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] half_len,
  input  logic [DT_W-1:0]  dead_len,
  input  logic [CNT_W-1:0] sr_len,
  input  logic             dir_bwd,
  input  logic             half_br,
  output logic [7:0]       gate,
  output logic             hp_start
);

  logic [CNT_W-1:0] cnt_q, h_q, s_q;
  logic [DT_W-1:0]  d_q;
  logic             phase_q, run_q, dir_q, hb_q;
  logic [7:0]       gate_q;
  logic             hp_q;

  logic [CNT_W-1:0] h_floor, h_new, span_new, s_new;
  logic             last, act, sr_on;
  logic             pa, pb, ra, rb;
  logic [7:0]       gate_d;

  assign h_floor  = CNT_W'(dead_len) + CNT_W'(2);
  assign h_new    = (half_len < h_floor) ? h_floor : half_len;
  assign span_new = h_new - CNT_W'(dead_len);
  assign s_new    = (sr_len > span_new) ? span_new : sr_len;

  assign last  = (cnt_q == h_q - CNT_W'(1));
  assign act   = (cnt_q >= CNT_W'(d_q));
  assign sr_on = act && ((cnt_q - CNT_W'(d_q)) < s_q);

  assign pa = run_q & ~phase_q & act;
  assign pb = run_q &  phase_q & act;
  assign ra = run_q & ~phase_q & sr_on;
  assign rb = run_q &  phase_q & sr_on;

  always_comb begin
    gate_d = '0;
    if (dir_q) begin
      gate_d[4] = pa;
      gate_d[7] = pa;
      gate_d[5] = pb;
      gate_d[6] = pb;
    end else begin
      gate_d[0] = pa;
      gate_d[1] = pb;
      gate_d[2] = hb_q ? 1'b0  : pb;
      gate_d[3] = hb_q ? run_q : pa;
      gate_d[4] = ra;
      gate_d[7] = ra;
      gate_d[5] = rb;
      gate_d[6] = rb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      h_q     <= '0;
      s_q     <= '0;
      d_q     <= '0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      hb_q    <= 1'b0;
      gate_q  <= '0;
      hp_q    <= 1'b0;
    end else if (!en) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      gate_q  <= '0;
      hp_q    <= 1'b0;
    end else begin
      gate_q <= gate_d;
      hp_q   <= run_q && (cnt_q == '0);
      run_q  <= 1'b1;
      if (!run_q || last) begin
        cnt_q   <= '0;
        phase_q <= run_q ? ~phase_q : 1'b0;
        h_q     <= h_new;
        d_q     <= dead_len;
        s_q     <= s_new;
        if (!run_q || phase_q) begin
          dir_q <= dir_bwd;
          hb_q  <= half_br;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign gate     = gate_q;
  assign hp_start = hp_q;

endmodule

// File: rtl/rgate_timer_chk.sv
module rgate_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [7:0] gate,
  input logic       hp_start,
  input logic       run,
  input logic       dir_q,
  input logic       hb_q
);

  AST_RECT_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    (gate[4] == gate[7]) && (gate[5] == gate[6])); // R1

  AST_PRI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1])); // R2

  AST_RECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[4] && gate[5])); // R5

  AST_BWD_PRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir_q && en) |=> (gate[3:0] == 4'b0000)); // R6

  AST_HB_STATIC_LEG: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hb_q && !dir_q && en) |=> (gate[3] && !gate[2])); // R7

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((gate == 8'h00) && !hp_start)); // R10

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hp_start |=> !hp_start); // R12

endmodule

bind rgate_timer rgate_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .gate     (gate),
  .hp_start (hp_start),
  .run      (run_q),
  .dir_q    (dir_q),
  .hb_q     (hb_q)
);

// File: tb/sim_rgate_timer.sv
`timescale 1ns/1ps
module sim_rgate_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] half_len = 16'd20;
  logic [7:0]  dead_len = 8'd3;
  logic [15:0] sr_len = 16'd10;
  logic        dir_bwd = 1'b0;
  logic        half_br = 1'b0;
  logic [7:0]  gate;
  logic        hp_start;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rgate_timer u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .half_len(half_len), .dead_len(dead_len), .sr_len(sr_len),
    .dir_bwd(dir_bwd), .half_br(half_br),
    .gate(gate), .hp_start(hp_start)
  );

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expg(input bit pa, input int k, input int H, input int D,
                                      input int S, input bit dir, input bit hb);
    logic [7:0] g;
    int se;
    bit a, r;
    g  = '0;
    se = (S > H - D) ? H - D : S;
    a  = (k >= D);
    r  = (k >= D) && (k < D + se);
    if (dir) begin
      if (pa) begin g[4] = a; g[7] = a; end
      else    begin g[5] = a; g[6] = a; end
    end else begin
      if (hb) begin
        g[3] = 1'b1;
        if (pa) g[0] = a; else g[1] = a;
      end else if (pa) begin
        g[0] = a; g[3] = a;
      end else begin
        g[1] = a; g[2] = a;
      end
      if (pa) begin g[4] = r; g[7] = r; end
      else    begin g[5] = r; g[6] = r; end
    end
    return g;
  endfunction

  task automatic run_half(input bit pa, input int H, input int D, input int S,
                          input bit dir, input bit hb, input string tag,
                          input int chg_k, input int nH, input int nD, input int nS,
                          input bit ndir, input bit nhb);
    int bad = 0;
    int bad_hp = 0;
    logic [7:0] a_g = '0;
    logic [7:0] e_g = '0;
    int bad_k = 0;
    for (int k = 0; k < H; k++) begin
      if (gate !== expg(pa, k, H, D, S, dir, hb)) begin
        if (bad == 0) begin
          a_g = gate;
          e_g = expg(pa, k, H, D, S, dir, hb);
          bad_k = k;
        end
        bad++;
      end
      if (hp_start !== (k == 0)) bad_hp++;
      if (k == chg_k) begin
        half_len = 16'(nH);
        dead_len = 8'(nD);
        sr_len   = 16'(nS);
        dir_bwd  = ndir;
        half_br  = nhb;
      end
      @(negedge clk);
    end
    chk(bad == 0, $sformatf("%s gates phase %s at k=%0d", tag, pa ? "A" : "B", bad_k), a_g, e_g);
    chk(bad_hp == 0, $sformatf("R12 strobe pattern (%s)", tag), bad_hp, 0);
  endtask

  task automatic plain_half(input bit pa, input int H, input int D, input int S,
                            input bit dir, input bit hb, input string tag);
    run_half(pa, H, D, S, dir, hb, tag, -1, 0, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic start(input int H, input int D, input int S, input bit dir, input bit hb);
    int waited = 0;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk((gate === 8'h00) && (hp_start === 1'b0), "R10 disabled outputs", {23'b0, hp_start, gate}, 0);
    half_len = 16'(H);
    dead_len = 8'(D);
    sr_len   = 16'(S);
    dir_bwd  = dir;
    half_br  = hb;
    en = 1'b1;
    while (waited < 50) begin
      @(negedge clk);
      waited++;
      if (hp_start === 1'b1) break;
    end
    chk(waited == 2, "R10 first strobe delay", waited, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk((gate === 8'h00) && (hp_start === 1'b0), "R10 reset outputs", {23'b0, hp_start, gate}, 0);
    rst_n = 1'b1;

    // Forward full-bridge operation
    start(20, 3, 10, 1'b0, 1'b0);
    plain_half(1'b1, 20, 3, 10, 1'b0, 1'b0, "R1 R2 R3 R4");
    plain_half(1'b0, 20, 3, 10, 1'b0, 1'b0, "R1 R2 R3 R4");
    plain_half(1'b1, 20, 3, 10, 1'b0, 1'b0, "R1 R2 R3 R4");
    plain_half(1'b0, 20, 3, 10, 1'b0, 1'b0, "R1 R2 R3 R4");

    // Rectifier on-time clamping
    start(20, 3, 40, 1'b0, 1'b0);
    plain_half(1'b1, 20, 3, 40, 1'b0, 1'b0, "R5 clamp");
    plain_half(1'b0, 20, 3, 40, 1'b0, 1'b0, "R5 clamp");
    start(16, 0, 16, 1'b0, 1'b0);
    plain_half(1'b1, 16, 0, 16, 1'b0, 1'b0, "R5 zero dead");
    plain_half(1'b0, 16, 0, 16, 1'b0, 1'b0, "R5 zero dead");

    // Backward operation
    start(24, 4, 5, 1'b1, 1'b0);
    plain_half(1'b1, 24, 4, 5, 1'b1, 1'b0, "R6 backward");
    plain_half(1'b0, 24, 4, 5, 1'b1, 1'b0, "R6 backward");
    start(24, 4, 5, 1'b1, 1'b1);
    plain_half(1'b1, 24, 4, 5, 1'b1, 1'b0, "R7 half-bridge ignored backward");
    plain_half(1'b0, 24, 4, 5, 1'b1, 1'b0, "R7 half-bridge ignored backward");

    // Forward half-bridge operation
    start(18, 2, 8, 1'b0, 1'b1);
    plain_half(1'b1, 18, 2, 8, 1'b0, 1'b1, "R7 half-bridge");
    plain_half(1'b0, 18, 2, 8, 1'b0, 1'b1, "R7 half-bridge");
    plain_half(1'b1, 18, 2, 8, 1'b0, 1'b1, "R7 half-bridge");

    // Timing-word changes in the middle of a half-period
    start(20, 3, 10, 1'b0, 1'b0);
    run_half(1'b1, 20, 3, 10, 1'b0, 1'b0, "R8 before change", 5, 30, 5, 12, 1'b0, 1'b0);
    plain_half(1'b0, 30, 5, 12, 1'b0, 1'b0, "R8 after change");
    plain_half(1'b1, 30, 5, 12, 1'b0, 1'b0, "R8 after change");

    // Mode changes in the middle of a period
    start(20, 3, 10, 1'b0, 1'b0);
    run_half(1'b1, 20, 3, 10, 1'b0, 1'b0, "R9 forward", 5, 20, 3, 10, 1'b1, 1'b0);
    plain_half(1'b0, 20, 3, 10, 1'b0, 1'b0, "R9 old mode kept in B");
    plain_half(1'b1, 20, 3, 10, 1'b1, 1'b0, "R9 backward applied");
    run_half(1'b0, 20, 3, 10, 1'b1, 1'b0, "R9 backward", 4, 20, 3, 10, 1'b0, 1'b1);
    plain_half(1'b1, 20, 3, 10, 1'b0, 1'b1, "R9 half-bridge applied");
    plain_half(1'b0, 20, 3, 10, 1'b0, 1'b1, "R9 half-bridge applied");

    // Half-period count below its minimum
    start(2, 4, 1, 1'b0, 1'b0);
    plain_half(1'b1, 6, 4, 1, 1'b0, 1'b0, "R11 minimum half-period");
    plain_half(1'b0, 6, 4, 1, 1'b0, 1'b0, "R11 minimum half-period");

    // Enable removed while running
    start(20, 3, 10, 1'b0, 1'b0);
    plain_half(1'b1, 20, 3, 10, 1'b0, 1'b0, "R2 before disable");
    repeat (6) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk((gate === 8'h00) && (hp_start === 1'b0), "R10 disable mid-run", {23'b0, hp_start, gate}, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule